// File: doc/BRIEF.md
# Power Event Serial Packet Transmitter

This block gathers processor activity events into an 8-bit sticky packet and sends that packet on a single serial line at a programmable interval. Each event source has an enable bit. A source with its enable clear is never recorded. An address-range match input drives packet bit 1, alongside strobe bit 1. Once a bit is recorded it stays set until the packet that carries it has been sent.

The line idles low while an interval counter runs down. When the counter expires, the line goes high for two clocks as a start marker. The eight packet bits then follow, most significant bit first, one clock each. A single high clock ends the frame, and the line then returns low for the next interval. The packet is taken into a shift register at the edge where the start marker begins. The bits taken are cleared, and events that arrive later are kept for the next frame.

A 2-bit select picks one of four interval lengths, each given in clock cycles as a parameter. The select is sampled when the counter reloads.

Top module: `pwr_evt_serializer`

## Requirements
- R1: While reset is asserted, `ser_out` is low. After reset the line stays low for `IVL0`..`IVL3` cycles plus one before the first frame.
- R2: Between the end marker of one frame and the start marker of the next, `ser_out` is low for exactly N cycles. N is `IVL0`, `IVL1`, `IVL2` or `IVL3` for `ivl_sel` = 0, 1, 2 or 3, sampled in the end-marker cycle.
- R3: Every frame begins with `ser_out` high for exactly two consecutive cycles.
- R4: After the start marker, the eight packet bits appear on `ser_out` one cycle each, bit 7 first and bit 0 last.
- R5: After bit 0, `ser_out` is high for exactly one cycle and then low.
- R6: A frame carries only events recorded since the previous frame was captured. A frame with no recorded events sends eight zeros.
- R7: `evt_strobe[i]` sets packet bit i only in a cycle where `evt_enable[i]` is 1. Otherwise it has no effect on any later frame.
- R8: `range_hit` sets packet bit 1 when `evt_enable[1]` is 1, and has no effect when it is 0.
- R9: No event is lost. An event present at the capture edge goes into the frame being started. An event that arrives during a transmission goes into the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 8 | Event strobes, one per packet bit |
| evt_enable | input | 8 | Per-bit recording enables |
| ivl_sel | input | 2 | Interval length select |
| range_hit | input | 1 | Address-range match event, feeds bit 1 |
| ser_out | output | 1 | Serial packet line, idles low |

## Verification
The bench drives events in the cycle of the capture edge and during every phase of a frame. A design that latched the packet one cycle late, or that cleared the whole register after sending, would drop or duplicate those events in the decoded frames.

Long runs of disabled strobes and `range_hit` with bit 1 masked must produce all-zero frames. This exposes gating applied to the wrong bit, or a match input that bypasses its enable.

The interval select changes between frames, and the low gap is timed against the value sampled in the end-marker cycle. An off-by-one reload would lengthen or shorten every gap by one cycle. A start marker of the wrong length would shift all eight decoded bits.

// File: rtl/pwr_evt_serializer.sv
module pwr_evt_serializer #(
  parameter int unsigned IVL0 = 100,
  parameter int unsigned IVL1 = 250,
  parameter int unsigned IVL2 = 500,
  parameter int unsigned IVL3 = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_strobe,
  input  logic [7:0] evt_enable,
  input  logic [1:0] ivl_sel,
  input  logic       range_hit,
  output logic       ser_out
);

  localparam int unsigned M01  = (IVL0 > IVL1) ? IVL0 : IVL1;
  localparam int unsigned M23  = (IVL2 > IVL3) ? IVL2 : IVL3;
  localparam int unsigned RMAX = (M01 > M23) ? M01 : M23;
  localparam int CW = $clog2(RMAX + 1);

  typedef enum logic [2:0] {S_ARM, S_WAIT, S_ST1, S_ST2, S_DATA, S_END} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  reload;
  logic [7:0]     pkt, shreg, ev;
  logic [2:0]     bitc;
  logic           capture;

  assign ev      = (evt_strobe & evt_enable) | {6'b0, range_hit & evt_enable[1], 1'b0};
  assign capture = (st == S_WAIT) && (cnt == '0);
  assign ser_out = (st == S_ST1) || (st == S_ST2) || (st == S_END) ||
                   ((st == S_DATA) && shreg[7]);

  always_comb begin
    case (ivl_sel)
      2'd0:    reload = CW'(IVL0 - 1);
      2'd1:    reload = CW'(IVL1 - 1);
      2'd2:    reload = CW'(IVL2 - 1);
      default: reload = CW'(IVL3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_ARM;
      cnt   <= '0;
      pkt   <= '0;
      shreg <= '0;
      bitc  <= '0;
    end else begin
      pkt <= capture ? 8'h00 : (pkt | ev);
      case (st)
        S_ARM: begin
          cnt <= reload;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (capture) begin
            shreg <= pkt | ev;
            st    <= S_ST1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ST1: st <= S_ST2;
        S_ST2: begin
          bitc <= '0;
          st   <= S_DATA;
        end
        S_DATA: begin
          shreg <= {shreg[6:0], 1'b0};
          bitc  <= bitc + 1'b1;
          if (bitc == 3'd7) st <= S_END;
        end
        S_END: begin
          cnt <= reload;
          st  <= S_WAIT;
        end
        default: st <= S_ARM;
      endcase
    end
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT || st == S_ARM) |-> !ser_out);

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && cnt != '0) |=> (st == S_WAIT && cnt == $past(cnt) - 1'b1 && !ser_out));

  assert_start_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ser_out && st == S_ST1));

  assert_start_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ST1) |=> ser_out);

  assert_end_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END) |=> !ser_out);

  assert_keep_events_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ((pkt & $past(ev)) == $past(ev)));

  assert_capture_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (shreg == ($past(pkt) | $past(ev))));

endmodule

// File: tb/pwr_evt_serializer_test.sv
module pwr_evt_serializer_test;

  localparam int unsigned P0 = 10, P1 = 17, P2 = 25, P3 = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_strobe = '0, evt_enable = '0;
  logic [1:0] ivl_sel = '0;
  logic       range_hit = 1'b0;
  logic       ser_out;

  int checks = 0, fails = 0;

  pwr_evt_serializer #(.IVL0(P0), .IVL1(P1), .IVL2(P2), .IVL3(P3)) uut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_enable(evt_enable),
    .ivl_sel(ivl_sel), .range_hit(range_hit), .ser_out(ser_out));

  always #5 clk = ~clk;

  function automatic logic [7:0] ev_fn(logic [7:0] s, logic [7:0] e, logic h);
    return (s & e) | {6'b0, h & e[1], 1'b0};
  endfunction

  function automatic int ivl_fn(logic [1:0] sel);
    case (sel)
      2'd0: return P0;
      2'd1: return P1;
      2'd2: return P2;
      default: return P3;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [7:0] acc = '0, ev_prev = '0, exp_frame = '0, got = '0;
  int phase = 0, lowcnt = 0, bits = 0, exp_gap = 0, frames = 0;
  bit have_gap = 0, pend_reload = 0, first = 1;

  task automatic observe();
    acc |= ev_prev;
    case (phase)
      0: begin
        if (ser_out) begin
          if (have_gap) check(lowcnt == exp_gap, "R2 low gap", lowcnt, exp_gap);
          else if (first) check(lowcnt == P0, "R1 first gap", lowcnt, P0);
          first = 0;
          exp_frame = acc;
          acc = '0;
          phase = 1;
        end else begin
          lowcnt++;
          if (lowcnt > 200) begin
            check(0, "R2 watchdog", lowcnt, exp_gap);
            lowcnt = 0;
          end
        end
      end
      1: begin
        check(ser_out == 1'b1, "R3 second start cycle", ser_out, 1);
        phase = 2; bits = 0; got = '0;
      end
      2: begin
        got = {got[6:0], ser_out};
        bits++;
        if (bits == 8) phase = 3;
      end
      default: begin
        check(ser_out == 1'b1, "R5 end marker", ser_out, 1);
        check(got == exp_frame, "R4 R6 R7 R8 R9 frame data", got, exp_frame);
        frames++;
        pend_reload = 1;
        lowcnt = 0;
        phase = 0;
      end
    endcase
  endtask

  task automatic drive(logic [7:0] s, logic [7:0] e, logic h, logic [1:0] sel);
    evt_strobe = s; evt_enable = e; range_hit = h; ivl_sel = sel;
    ev_prev = ev_fn(s, e, h);
    if (pend_reload) begin
      exp_gap = ivl_fn(sel);
      have_gap = 1;
      pend_reload = 0;
    end
  endtask

  task automatic step(logic [7:0] s, logic [7:0] e, logic h, logic [1:0] sel);
    @(negedge clk);
    observe();
    drive(s, e, h, sel);
  endtask

  initial begin
    logic [1:0] sel;
    logic [7:0] en;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ser_out == 1'b0, "R1 low in reset", ser_out, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7: strobes with every enable clear
    for (int i = 0; i < 120; i++) step($urandom, 8'h00, 1'b0, 2'd0);
    // R8: range match masked, then enabled alone
    for (int i = 0; i < 80; i++) step(8'h00, 8'hFD, 1'b1, 2'd1);
    for (int i = 0; i < 80; i++) step(8'h00, 8'h02, (i % 9) == 0, 2'd1);
    // R6: no events gives an all-zero frame
    for (int i = 0; i < 60; i++) step(8'h00, 8'hFF, 1'b0, 2'd0);
    // every bit set
    for (int i = 0; i < 60; i++) step(8'hFF, 8'hFF, 1'b1, 2'd2);
    // R9: random mix spanning all phases
    sel = 2'd0; en = 8'hFF;
    for (int i = 0; i < 6000; i++) begin
      if (i % 350 == 0) begin
        sel = 2'($urandom);
        en = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFF;
      end
      step(($urandom % 6 == 0) ? 8'($urandom) : 8'h00, en,
           ($urandom % 11) == 0, ($urandom % 40 == 0) ? 2'($urandom) : sel);
    end
    check(frames > 100, "R2 frame count", frames, 100);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule